// File: doc/BRIEF.md
# USB Line Edge Interrupt Controller

This block watches four single-bit USB line levels: D+, D−, ID and Vbus. It raises an interrupt when an enabled line changes level in a chosen direction. Each line has two enable bits in an 8-bit event-mask register, one for a rising edge and one for a falling edge. When an enabled edge is seen, the matching bit of an 8-bit cause register is set and held. The interrupt output then asserts, and an active-low pending flag in a status register goes low.

Software uses a small register bus with a 2-bit address, a write strobe, write data and combinational read data. It finds out why the interrupt fired by reading the cause register. It acknowledges an event by writing the mask with that event's enable bit cleared, which also clears the matching cause bit. Only edges count, not levels: an enable bit set while its line already sits at the target level produces nothing until the line leaves that level and comes back. The line inputs are taken to be synchronous to `clk` already.

Register map: address 0 is the mask (read/write), address 1 is the cause (read-only), address 2 is the status (read-only), and address 3 reads as zero.

Top module: `usb_line_irq`

## Requirements
- R1: The mask register at address 0 resets to 0x00. A write to address 0 loads all eight bits on the next clock, and reading address 0 returns exactly the value last written.
- R2: For D+, D− and ID, the even bit enables the falling edge and the odd bit enables the rising edge: D+ uses bits 0/1, D− uses bits 2/3 and ID uses bits 4/5.
- R3: For Vbus the order is reversed: bit 6 enables the rising edge and bit 7 enables the falling edge.
- R4: A cause bit is set only when its line changes level in its direction while the enable bit is already set in the mask. Setting an enable while the line already sits at the target level causes no event. An edge on a line whose enable is clear causes no event.
- R5: The cause register at address 1 uses the mask's bit positions. Each cause bit becomes readable on the first clock edge after the line change. It then stays set, including after the line returns to its old level, until it is acknowledged.
- R6: The status register at address 2 reads 0xFF when no cause bit is set and 0xFB (bit 2 low) while any cause bit is set. Output `irq` is high exactly when any cause bit is set.
- R7: Writing the mask with an enable bit cleared clears the matching cause bit on the same clock. Cause bits whose enables stay set are kept.
- R8: If an edge and a mask write that clears the same bit fall on the same clock, the cause bit ends up clear.
- R9: After reset the mask and cause registers read 0x00, and lines that are high during reset produce no event when reset is released.
- R10: Writes to addresses 1, 2 and 3 change neither the mask nor the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWe | input | 1 | Write strobe, one clock per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| lineDp | input | 1 | D+ level |
| lineDm | input | 1 | D− level |
| lineId | input | 1 | ID level |
| lineVbus | input | 1 | Vbus level |
| irq | output | 1 | High while any cause bit is set |

## Verification
Read data is combinational, so a register read is due in the same cycle its address is applied. A line change or mask write applied after a falling clock edge shows up in the registers after the next rising edge. The bench applies every stimulus at a falling edge. It issues each read at the following falling edge, one rising edge later, and the monitor compares one time unit after that, well clear of any rising edge. Stimuli that must share a clock, such as an edge together with a clearing write, are applied at the same falling edge. The expected values come from a small model of the mask and cause registers that the driver updates as it applies each stimulus.

// File: rtl/usb_line_irq_pkg.sv
package usb_line_irq_pkg;

  typedef enum logic [1:0] {
    REG_MASK   = 2'd0,
    REG_CAUSE  = 2'd1,
    REG_STATUS = 2'd2,
    REG_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic maskWe;
  } ctlStrobes_t;

endpackage

// File: rtl/usb_line_irq_datapath.sv
module usb_line_irq_datapath
  import usb_line_irq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter logic [NUM_LINES-1:0] RISE_FIRST = 4'b1000,
  localparam int EVT_W = 2 * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  ctlStrobes_t          strobes,
  input  logic [EVT_W-1:0]     wdata,
  output logic [EVT_W-1:0]     mask,
  output logic [EVT_W-1:0]     cause
);

  logic [NUM_LINES-1:0] prevLines;
  logic [EVT_W-1:0]     edgeVec;
  logic [EVT_W-1:0]     hits;
  logic [EVT_W-1:0]     causeNext;

  // Previous level loads the live level during reset, so no false edge follows
  always_ff @(posedge clk) begin
    prevLines <= lines;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic riseEdge;
    logic fallEdge;
    assign riseEdge = !prevLines[g] && lines[g];
    assign fallEdge = prevLines[g] && !lines[g];
    if (RISE_FIRST[g]) begin : gRiseLow
      assign edgeVec[2*g]   = riseEdge;
      assign edgeVec[2*g+1] = fallEdge;
    end else begin : gFallLow
      assign edgeVec[2*g]   = fallEdge;
      assign edgeVec[2*g+1] = riseEdge;
    end
  end

  assign hits = edgeVec & mask;

  always_comb begin
    causeNext = cause | hits;
    if (strobes.maskWe) begin
      causeNext = causeNext & wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '0;
      cause <= '0;
    end else begin
      if (strobes.maskWe) begin
        mask <= wdata;
      end
      cause <= causeNext;
    end
  end

  // R1
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.maskWe |=> mask == $past(wdata));

  // R7
  cause_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~mask) == '0);

  // R4
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lines) && !strobes.maskWe) |=> $stable(cause));

endmodule

// File: rtl/usb_line_irq_control.sv
module usb_line_irq_control
  import usb_line_irq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int PEND_BIT  = 2,
  localparam int EVT_W = 2 * NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       busAddr,
  input  logic             busWe,
  input  logic [EVT_W-1:0] mask,
  input  logic [EVT_W-1:0] cause,
  output ctlStrobes_t      strobes,
  output logic [EVT_W-1:0] busRdata,
  output logic             irq
);

  regSel_e sel;
  logic    anyPending;

  assign sel        = regSel_e'(busAddr);
  assign anyPending = |cause;
  assign irq        = anyPending;

  always_comb begin
    strobes        = '0;
    strobes.maskWe = busWe && (sel == REG_MASK);
  end

  always_comb begin
    unique case (sel)
      REG_MASK:   busRdata = mask;
      REG_CAUSE:  busRdata = cause;
      REG_STATUS: begin
        busRdata           = '1;
        busRdata[PEND_BIT] = !anyPending;
      end
      default:    busRdata = '0;
    endcase
  end

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && sel != REG_MASK) |-> !strobes.maskWe);

  // R6
  pend_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_STATUS) |-> (busRdata[PEND_BIT] != irq));

endmodule

// File: rtl/usb_line_irq.sv
module usb_line_irq
  import usb_line_irq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int EVT_W = 2 * NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       busAddr,
  input  logic             busWe,
  input  logic [EVT_W-1:0] busWdata,
  output logic [EVT_W-1:0] busRdata,
  input  logic             lineDp,
  input  logic             lineDm,
  input  logic             lineId,
  input  logic             lineVbus,
  output logic             irq
);

  ctlStrobes_t     strobes;
  logic [EVT_W-1:0] mask;
  logic [EVT_W-1:0] cause;

  usb_line_irq_control #(.NUM_LINES(NUM_LINES), .PEND_BIT(2)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .mask     (mask),
    .cause    (cause),
    .strobes  (strobes),
    .busRdata (busRdata),
    .irq      (irq)
  );

  usb_line_irq_datapath #(.NUM_LINES(NUM_LINES), .RISE_FIRST(4'b1000)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   ({lineVbus, lineId, lineDm, lineDp}),
    .strobes (strobes),
    .wdata   (busWdata),
    .mask    (mask),
    .cause   (cause)
  );

endmodule

// File: tb/usb_line_irq_tb.sv
`timescale 1ns/1ps
module usb_line_irq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [3:0] lines = 4'b1111;  // {vbus, id, dm, dp}
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_line_irq u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .lineDp(lines[0]), .lineDm(lines[1]), .lineId(lines[2]), .lineVbus(lines[3]),
    .irq(irq)
  );

  typedef struct {
    logic [1:0] addr;
    logic [7:0] expData;
    logic       expIrq;
    string      req;
  } item_t;

  item_t sbq[$];

  logic [7:0] expMask  = 8'h00;
  logic [7:0] expCause = 8'h00;
  logic [3:0] curLines = 4'b1111;

  function automatic logic [7:0] evts(logic [3:0] o, logic [3:0] n);
    logic [7:0] v = '0;
    for (int l = 0; l < 3; l++) begin
      v[2*l]   = o[l] && !n[l];
      v[2*l+1] = !o[l] && n[l];
    end
    v[6] = !o[3] && n[3];
    v[7] = o[3] && !n[3];
    return v;
  endfunction

  function automatic logic [7:0] modelRead(logic [1:0] a);
    case (a)
      2'd0: return expMask;
      2'd1: return expCause;
      2'd2: return (expCause != 0) ? 8'hFB : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // Drive one cycle: optional write plus new line levels, same falling edge
  task automatic step(bit doWr, logic [1:0] a, logic [7:0] d, logic [3:0] nl);
    logic [7:0] hits;
    @(negedge clk);
    busWe = doWr; busAddr = a; busWdata = d; lines = nl;
    hits = evts(curLines, nl) & expMask;
    expCause = expCause | hits;
    if (doWr && a == 2'd0) begin
      expMask  = d;
      expCause = expCause & d;
    end
    curLines = nl;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(1'b1, a, d, curLines);
  endtask

  task automatic setLines(logic [3:0] nl);
    step(1'b0, 2'd0, 8'h00, nl);
  endtask

  task automatic rd(logic [1:0] a, string req);
    item_t it;
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    it.addr = a; it.expData = modelRead(a); it.expIrq = (expCause != 0); it.req = req;
    sbq.push_back(it);
  endtask

  task automatic rdLit(logic [1:0] a, logic [7:0] v, string req);
    item_t it;
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    it.addr = a; it.expData = v; it.expIrq = (expCause != 0); it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: compares one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (busRdata !== it.expData || irq !== it.expIrq) begin
          errors++;
          $display("FAIL %s addr=%0d: rdata=%02h irq=%b expected rdata=%02h irq=%b",
                   it.req, it.addr, busRdata, irq, it.expData, it.expIrq);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: reset state, high lines give no event
    rdLit(2'd0, 8'h00, "R9 mask");
    rdLit(2'd1, 8'h00, "R9 cause");
    rdLit(2'd2, 8'hFF, "R9 status");
    // R1: mask readback
    wr(2'd0, 8'hA5); rdLit(2'd0, 8'hA5, "R1");
    wr(2'd0, 8'h5A); rdLit(2'd0, 8'h5A, "R1");
    // R4: enable while already at level -> nothing
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    repeat (2) rdLit(2'd1, 8'h00, "R4 enable-at-level");
    // R2: D+ fall then rise
    setLines(4'b1110); rdLit(2'd1, 8'h01, "R2 dp fall");
    setLines(4'b1111); rdLit(2'd1, 8'h03, "R2 dp rise");
    // R6: pending status
    rdLit(2'd2, 8'hFB, "R6 status pending");
    // R7: acknowledge one bit, then the other
    wr(2'd0, 8'hFE); rdLit(2'd1, 8'h02, "R7 partial ack");
    wr(2'd0, 8'hFC); rdLit(2'd1, 8'h00, "R7 full ack");
    rdLit(2'd2, 8'hFF, "R6 status clear");
    // R2: D- and ID falls, then rises
    wr(2'd0, 8'hFF);
    setLines(4'b1101); rdLit(2'd1, 8'h04, "R2 dm fall");
    setLines(4'b1001); rdLit(2'd1, 8'h14, "R2 id fall");
    setLines(4'b1111); rdLit(2'd1, 8'h3C, "R2 dm/id rise");
    // R5: sticky across idle cycles
    repeat (3) rd(2'd1, "R5 sticky");
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    // R3: Vbus reversed order
    setLines(4'b0111); rdLit(2'd1, 8'h80, "R3 vbus fall");
    setLines(4'b1111); rdLit(2'd1, 8'hC0, "R3 vbus rise");
    // R10: read-only writes ignored
    wr(2'd1, 8'h00); rdLit(2'd1, 8'hC0, "R10 cause write");
    wr(2'd2, 8'h00); rdLit(2'd0, 8'hFF, "R10 status write mask");
    wr(2'd3, 8'h00); rdLit(2'd1, 8'hC0, "R10 addr3 write");
    // R8: edge and clearing write in the same cycle
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    step(1'b1, 2'd0, 8'h00, 4'b1110);
    rdLit(2'd1, 8'h00, "R8 clear wins");
    rdLit(2'd2, 8'hFF, "R8 status");
    // R4: disabled line edges ignored
    setLines(4'b0000); setLines(4'b1111);
    rdLit(2'd1, 8'h00, "R4 disabled");
    // R4: only enabled direction fires
    wr(2'd0, 8'h02);
    setLines(4'b1110); rdLit(2'd1, 8'h00, "R4 wrong direction");
    setLines(4'b1111); rdLit(2'd1, 8'h02, "R4 right direction");
    // R9: reset clears everything, lines held low through reset
    @(negedge clk); rst_n = 1'b0; lines = 4'b0000; curLines = 4'b0000;
    expMask = 8'h00; expCause = 8'h00;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rdLit(2'd1, 8'h00, "R9 after reset");
    rdLit(2'd0, 8'h00, "R9 mask after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule